// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a two-bank synchronous burst static RAM whose read path is flow-through. Each word is 72 bits wide: 64 data bits and 8 parity bits, stored and returned unchanged. Address, strobes, write control and bank enables are all captured on the rising clock edge. Read data for the captured address reaches the output during the cycle that follows that edge, with no extra pipeline register. The output enable gates the output path without waiting for a clock.

Two address strobes start a burst. The processor-side strobe always starts a read, and only a bank whose enable is low can accept it. The controller-side strobe starts a read or a write, chosen by the global write input, or it deselects the block when no bank is enabled. Between strobes, the advance input either steps a 2-bit burst counter or holds it. The counter replaces the two lowest address bits, in linear or interleaved order as selected by a mode input. Each bank has its own enable and its own sleep input. The data buses are split into an input word and an output word, and an output-valid flag stands in for the high-impedance state.

Top module: `fts_burst_sram`

## Requirements
- R1: After synchronous reset no burst is active: `rvalid` is 0, and advance cycles produce no output until a strobe loads an address.
- R2: `adsp_n`=0 while at least one bank enable is low loads `addr` and starts a read regardless of `gw_n`. The addressed word appears on `rdata` with `rvalid`=1 in the cycle right after that edge (flow-through).
- R3: `adsp_n`=0 while both bank enables are high is ignored. The edge then behaves as if `adsp_n` were 1, so an active burst continues or holds on its old address.
- R4: `adsc_n`=0, `adsp_n`=1 with a bank enabled loads `addr`. The cycle writes the full 72-bit `wdata` when `gw_n`=0 and reads when `gw_n`=1.
- R5: `adsc_n`=0 with both bank enables high deselects the block. `rvalid` stays 0 and later advance or write cycles touch nothing until the next load.
- R6: With both strobes high and `adv_n`=0, the burst advances. With `mode_il`=0 the low two address bits step by +1 modulo 4 from the loaded value, the upper bits stay put, and each cycle reads or writes per `gw_n`.
- R7: With `mode_il`=1 the k-th word of a burst uses low bits equal to the loaded low bits XOR k (k = 0..3).
- R8: With both strobes high and `adv_n`=1 the burst is suspended. The same address is reused for a read or a write per `gw_n`.
- R9: When both bank enables are low at a load strobe, bank 0 (`en_n[0]`) is chosen.
- R10: While `sleep[b]`=1, writes aimed at bank b are discarded and a read of bank b gives `rvalid`=0. Clearing `sleep[b]` makes a read in progress visible again.
- R11: `oe_n`=1 forces `rvalid` to 0 at once, without a clock edge. `oe_n`=0 restores it.
- R12: The two banks are separate arrays: one address in bank 0 and bank 1 holds independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| adsc_n | input | 1 | Controller address strobe, active low |
| adsp_n | input | 1 | Processor address strobe (read only), active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of the full word, active low |
| en_n | input | 2 | Per-bank enables, active low; bit 0 has priority |
| sleep | input | 2 | Per-bank sleep, active high |
| mode_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | DATA_W | Write word (64 data + 8 parity bits) |
| rdata | output | DATA_W | Read word, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The bench builds the block with the full 17-bit address and 72-bit word but only 6 array index bits, so each bank holds 64 words. This lets the behavioural reference keep a complete copy of both banks and flag any word that has never been written. With this small depth, every burst block, both banks, and same-address collisions between banks can be reached within a few hundred cycles. Mode changes between bursts, suspends within a burst, ignored strobes and sleep windows are all compared against the reference on every clock.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int NBANK = 2;

  // Low two address bits for burst position cnt, starting from start.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       il);
    return il ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/fts_burst_ctrl.sv
module fts_burst_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               adsc_n,
  input  logic               adsp_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic [1:0]         en_n,
  input  logic [1:0]         sleep,
  input  logic               mode_il,
  output logic               wr_en,
  output logic               wr_bank,
  output logic [DEPTH_W-1:0] wr_idx,
  output logic               act_q,
  output logic               bank_q,
  output logic               rd_q,
  output logic [ADDR_W-1:0]  cur_addr
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        start_q, start_n, cnt_q, cnt_n, lo_q, lo_n;
  logic              act_n, bank_n, rd_n;
  logic              any_en, tgt, ld_p, ld_c, dsl, mv;

  assign any_en = ~&en_n;
  assign tgt    = en_n[0];              // bank 0 wins when both are low
  assign ld_p   = !adsp_n && any_en;
  assign ld_c   = !ld_p && !adsc_n && any_en;
  assign dsl    = !ld_p && !adsc_n && !any_en;
  assign mv     = !ld_p && adsc_n && act_q;

  always_comb begin
    act_n   = act_q;
    bank_n  = bank_q;
    base_n  = base_q;
    start_n = start_q;
    cnt_n   = cnt_q;
    lo_n    = lo_q;
    rd_n    = rd_q;
    if (ld_p || ld_c) begin
      act_n   = 1'b1;
      bank_n  = tgt;
      base_n  = addr;
      start_n = addr[1:0];
      cnt_n   = 2'd0;
      lo_n    = addr[1:0];
      rd_n    = ld_p || gw_n;
    end else if (dsl) begin
      act_n = 1'b0;
    end else if (mv) begin
      cnt_n = adv_n ? cnt_q : cnt_q + 2'd1;
      lo_n  = adv_n ? lo_q : burst_lo(start_q, cnt_n, mode_il);
      rd_n  = gw_n;
    end
  end

  assign wr_en   = ((ld_c || mv) && !gw_n) && !sleep[bank_n];
  assign wr_bank = bank_n;
  assign wr_idx  = {base_n[DEPTH_W-1:2], lo_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      bank_q  <= 1'b0;
      base_q  <= '0;
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
      lo_q    <= 2'd0;
      rd_q    <= 1'b0;
    end else begin
      act_q   <= act_n;
      bank_q  <= bank_n;
      base_q  <= base_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
      lo_q    <= lo_n;
      rd_q    <= rd_n;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], lo_q};
endmodule

// File: rtl/fts_bank_mem.sv
module fts_bank_mem #(
  parameter int DATA_W  = 72,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DEPTH_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DEPTH_W-1:0] raddr,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 72,
  parameter int DEPTH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsc_n,
  input  logic              adsp_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic [1:0]        en_n,
  input  logic [1:0]        sleep,
  input  logic              mode_il,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic               wr_en, wr_bank, act_q, bank_q, rd_q;
  logic [DEPTH_W-1:0] wr_idx;
  logic [ADDR_W-1:0]  cur_addr;
  logic [DATA_W-1:0]  bank_rd [NBANK];

  fts_burst_ctrl #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .adsc_n(adsc_n), .adsp_n(adsp_n),
    .adv_n(adv_n), .gw_n(gw_n), .en_n(en_n), .sleep(sleep),
    .mode_il(mode_il), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .act_q(act_q), .bank_q(bank_q), .rd_q(rd_q), .cur_addr(cur_addr)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    fts_bank_mem #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_mem (
      .clk(clk),
      .we(wr_en && (wr_bank == g[0])),
      .waddr(wr_idx),
      .wdata(wdata),
      .raddr(cur_addr[DEPTH_W-1:0]),
      .rdata(bank_rd[g])
    );
  end

  assign rvalid = act_q && rd_q && !oe_n && !sleep[bank_q];
  assign rdata  = rvalid ? bank_rd[bank_q] : '0;
endmodule

// File: rtl/fts_sva.sv
module fts_sva #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              adsc_n,
  input logic              adsp_n,
  input logic              adv_n,
  input logic [1:0]        en_n,
  input logic [1:0]        sleep,
  input logic              mode_il,
  input logic              oe_n,
  input logic              rvalid,
  input logic              act_q,
  input logic              rd_q,
  input logic [ADDR_W-1:0] cur_addr
);
  assert_rst_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid);

  assert_adsp_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !(&en_n)) |=> (act_q && rd_q));

  assert_desel_R5: assert property (@(posedge clk) disable iff (rst)
    (!adsc_n && (&en_n)) |=> !rvalid);

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (act_q && adsp_n && adsc_n && !adv_n && !mode_il)
      |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

  assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (act_q && adsp_n && adsc_n)
      |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  assert_suspend_R8: assert property (@(posedge clk) disable iff (rst)
    (act_q && adsp_n && adsc_n && adv_n) |=> $stable(cur_addr));

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (&sleep) |-> !rvalid);

  assert_oe_gate_R11: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rvalid);
endmodule

bind fts_burst_sram fts_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .adsc_n(adsc_n), .adsp_n(adsp_n), .adv_n(adv_n),
  .en_n(en_n), .sleep(sleep), .mode_il(mode_il), .oe_n(oe_n),
  .rvalid(rvalid), .act_q(act_q), .rd_q(rd_q), .cur_addr(cur_addr)
);

// File: tb/sim_fts_burst_sram.sv
`timescale 1ns/1ps
module sim_fts_burst_sram;
  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 72;
  localparam int DEPTH_W = 6;
  localparam int DEPTH   = 1 << DEPTH_W;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addr;
  logic              adsc_n, adsp_n, adv_n, gw_n, mode_il, oe_n;
  logic [1:0]        en_n, sleep;
  logic [DATA_W-1:0] wdata, rdata;
  logic              rvalid;

  always #2.5 clk = ~clk;

  fts_burst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .adsc_n(adsc_n), .adsp_n(adsp_n),
    .adv_n(adv_n), .gw_n(gw_n), .en_n(en_n), .sleep(sleep),
    .mode_il(mode_il), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid)
  );

  // Behavioural reference
  logic [DATA_W-1:0] ref_mem [2][DEPTH];
  bit                ref_ok  [2][DEPTH];
  int m_act = 0, m_bank = 0, m_rd = 0, m_start = 0, m_cnt = 0, m_lo = 0;
  int m_base = 0;
  int n_chk = 0, n_fail = 0;

  function automatic logic [DATA_W-1:0] pat(input int k);
    logic [31:0] h;
    h = k * 32'h9E37_79B1;
    return {k[7:0] ^ 8'hA5, h, ~h};
  endfunction

  function automatic int ref_idx();
    return ((m_base % DEPTH) & ~3) | m_lo;
  endfunction

  task automatic ref_edge();
    bit any;
    int tgt;
    any = !en_n[0] || !en_n[1];
    tgt = en_n[0] ? 1 : 0;
    if (rst) begin
      m_act = 0; m_bank = 0; m_rd = 0; m_start = 0; m_cnt = 0; m_lo = 0; m_base = 0;
    end else if (!adsp_n && any) begin
      m_act = 1; m_bank = tgt; m_base = int'(addr); m_start = int'(addr[1:0]);
      m_cnt = 0; m_lo = m_start; m_rd = 1;
    end else if (!adsc_n) begin
      if (any) begin
        m_act = 1; m_bank = tgt; m_base = int'(addr); m_start = int'(addr[1:0]);
        m_cnt = 0; m_lo = m_start; m_rd = gw_n;
        if (!gw_n && !sleep[m_bank]) begin
          ref_mem[m_bank][ref_idx()] = wdata; ref_ok[m_bank][ref_idx()] = 1;
        end
      end else m_act = 0;
    end else if (m_act != 0) begin
      if (!adv_n) begin
        m_cnt = (m_cnt + 1) & 3;
        m_lo  = mode_il ? (m_start ^ m_cnt) : ((m_start + m_cnt) & 3);
      end
      m_rd = gw_n;
      if (!gw_n && !sleep[m_bank]) begin
        ref_mem[m_bank][ref_idx()] = wdata; ref_ok[m_bank][ref_idx()] = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic ev;
    ev = (m_act != 0) && (m_rd != 0) && !oe_n && !sleep[m_bank];
    n_chk++;
    if (rvalid !== ev) begin
      n_fail++;
      $display("FAIL %s rvalid actual=%b expected=%b", tag, rvalid, ev);
    end else if (ev && ref_ok[m_bank][ref_idx()] &&
                 rdata !== ref_mem[m_bank][ref_idx()]) begin
      n_fail++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata,
               ref_mem[m_bank][ref_idx()]);
    end
  endtask

  // One clock: reference update at the edge, comparison 1 ns later.
  task automatic step(input string tag);
    @(posedge clk);
    ref_edge();
    #1;
    compare(tag);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; en_n = 2'b11;
  endtask

  task automatic expect_valid(input string tag, input logic exp);
    n_chk++;
    if (rvalid !== exp) begin
      n_fail++;
      $display("FAIL %s rvalid actual=%b expected=%b", tag, rvalid, exp);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; idle(); oe_n = 0; sleep = 2'b00; mode_il = 0; wdata = '0; addr = '0;
    repeat (3) step("R1");
    rst = 0;
    step("R1");
    adv_n = 0; step("R1"); step("R1"); adv_n = 1;

    // R4: write burst into bank 0 at 0x10..0x13 (linear)
    en_n = 2'b10; adsc_n = 0; gw_n = 0; addr = 17'h10; wdata = pat(1); step("R4");
    adsc_n = 1; en_n = 2'b11; adv_n = 0;
    for (int k = 2; k <= 4; k++) begin wdata = pat(k); step("R6"); end
    idle(); step("R6");

    // R2: processor strobe reads even with gw_n low; linear wrap R6
    en_n = 2'b10; adsp_n = 0; gw_n = 0; addr = 17'h12; step("R2");
    adsp_n = 1; en_n = 2'b11; gw_n = 1; adv_n = 0;
    repeat (3) step("R6");

    // R7: interleaved order from 0x11
    mode_il = 1; adv_n = 1;
    en_n = 2'b10; adsp_n = 0; addr = 17'h11; step("R7");
    adsp_n = 1; en_n = 2'b11; adv_n = 0;
    step("R7");
    // R8: suspend mid-burst
    adv_n = 1; step("R8"); step("R8");
    adv_n = 0; step("R7"); step("R7");
    mode_il = 0; idle();

    // R12: bank 1 gets different data at the same addresses
    en_n = 2'b01; adsc_n = 0; gw_n = 0; addr = 17'h10; wdata = pat(11); step("R12");
    adsc_n = 1; en_n = 2'b11; adv_n = 0;
    for (int k = 12; k <= 14; k++) begin wdata = pat(k); step("R12"); end
    idle();
    en_n = 2'b01; adsp_n = 0; addr = 17'h10; step("R12");
    adsp_n = 1; en_n = 2'b11; adv_n = 0; repeat (3) step("R12");
    idle();

    // R4: controller strobe read from bank 0
    en_n = 2'b10; adsc_n = 0; gw_n = 1; addr = 17'h11; step("R4");
    adsc_n = 1; en_n = 2'b11; adv_n = 0; step("R4");

    // R3: processor strobe with no bank enabled is ignored
    adsp_n = 0; en_n = 2'b11; addr = 17'h30; adv_n = 1; step("R3");
    adv_n = 0; step("R3");
    idle();

    // R9: both enables low -> bank 0
    en_n = 2'b00; adsp_n = 0; addr = 17'h10; step("R9");
    idle(); step("R9");

    // R5: deselect, then advance/write cycles do nothing
    adsc_n = 0; en_n = 2'b11; step("R5");
    adsc_n = 1; adv_n = 0; step("R5");
    gw_n = 0; wdata = pat(40); step("R5");
    idle();
    en_n = 2'b10; adsp_n = 0; addr = 17'h13; step("R5");
    idle(); step("R5");

    // R10: bank 1 asleep: write dropped, read hidden, then visible
    sleep = 2'b10;
    en_n = 2'b01; adsc_n = 0; gw_n = 0; addr = 17'h10; wdata = pat(30); step("R10");
    gw_n = 1; step("R10");
    idle(); step("R10");
    sleep = 2'b00; #1 compare("R10");
    step("R10");

    // R11: output enable acts without a clock
    oe_n = 1; #1 expect_valid("R11", 1'b0);
    oe_n = 0; #1 expect_valid("R11", 1'b1);
    step("R11");

    idle(); repeat (2) step("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule